// File: doc/BRIEF.md
# Iterative Integer Divider

This block is the divide unit of a 64-bit execution pipeline. A one-cycle start strobe presents a dividend, a divisor, a destination register number and the operation form. The form is chosen by five flags: signed, 32-bit, extended, modulus, and record-condition. The unit then runs a shift-subtract loop that retires one quotient bit per cycle. A fixed number of cycles later it emits a one-cycle completion pulse. The pulse carries a register write and, when requested, a write to one condition field.

Signed forms work on operand magnitudes. The quotient is negated when the operand signs differ, and the remainder is negated when the dividend is negative. Extended forms place the dividend in the upper half of a double-width numerator before dividing. The 32-bit forms take only the low half of each operand. The condition field compares the result with zero as a signed number, over the full width or over the low half.

Only one operation is in flight at a time. A start that arrives while the unit is busy is dropped.

Top module: `iter_divider`

## Requirements
- R1: A start strobe is accepted when the unit is idle, and `done_o` stays low in the cycle right after the accepting edge.
- R2: `done_o` rises no later than 66 cycles after the accepting edge (65 in this design) and stays high for exactly one cycle.
- R3: With `done_o`, `gpr_we_o` is high and `gpr_idx_o` equals the `dest_i` captured at start; `gpr_we_o` is low at all other times. Unsigned 0x10001000 / 0x1111 gives 0xF001.
- R4: `cr_we_o` pulses with `done_o` only when `rec_i` was set at start. The mask is then 8'b1000_0000. Bits 31..28 of `cr_data_o` hold {negative, positive, zero, 0}, and bits 27..0 are zero, so a positive result gives 0x40000000.
- R5: In 64-bit forms the condition code treats the whole result as signed. In 32-bit forms it treats only bits 31..0 as signed.
- R6: Signed division truncates toward zero (for example, -100 / 7 = -14 and 100 / -7 = -14), and unsigned division gives the floor.
- R7: In the extended 64-bit form the numerator is {dividend, 64 zero bits} and the result is the low 64 bits of the quotient, whenever that quotient fits.
- R8: In the modulus form the result is the truncating remainder, so a nonzero remainder has the dividend's sign (for example, -100 mod 7 = -2).
- R9: The 32-bit forms use only bits 31..0 of each operand, and only bits 31..0 of the result are defined. The extended 32-bit numerator is {dividend[31:0], 32 zero bits}.
- R10: A zero divisor still produces a `done_o` pulse within the R2 window. The data returned in that case is undefined.
- R11: A start strobe while an operation is in flight is ignored. Only the first operation's pulse appears, carrying its own register number and result.
- R12: A synchronous reset returns the unit to idle with all enables low, and it abandons any operation in flight, so that operation produces no pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start_i | input | 1 | One-cycle operation request |
| dest_i | input | 5 | Destination register number |
| dvd_i | input | 64 | Dividend |
| dvs_i | input | 64 | Divisor |
| sgn_i | input | 1 | Signed operands |
| w32_i | input | 1 | 32-bit form |
| ext_i | input | 1 | Extended form (numerator shifted up by the operand width) |
| mod_i | input | 1 | Return remainder instead of quotient |
| rec_i | input | 1 | Request condition field write |
| done_o | output | 1 | One-cycle completion pulse |
| gpr_we_o | output | 1 | Register write enable |
| gpr_idx_o | output | 5 | Register number being written |
| gpr_data_o | output | 64 | Result |
| cr_we_o | output | 1 | Condition field write enable |
| cr_mask_o | output | 8 | Condition field select mask |
| cr_data_o | output | 32 | Condition data, code in bits 31..28 |

## Verification
A fault in the iteration counter changes when the pulse arrives: it comes early, late, twice, or never. The bench therefore measures latency in cycles on every operation. A fault in the remainder or quotient shift registers shows up only in the result word of the one pulse. The bad bit position then depends on which iteration went wrong, so the vectors mix small and full-width quotients and remainders, with both signs. A sign flag latched wrongly at start leaves the magnitude correct but flips the sign and the condition code. A busy flag that is cleared too early or never set lets a second start overwrite the register number. That fault is visible in the same pulse.

// File: rtl/idiv_pkg.sv
package idiv_pkg;

   localparam int CODE_W = 4;

   typedef struct packed {
      logic sgn;
      logic w32;
      logic ext;
   } op_form_t;

   function automatic logic [CODE_W-1:0] zero_cmp_code(input logic is_neg, input logic is_zero);
      return {is_neg, ~is_neg & ~is_zero, is_zero, 1'b0};
   endfunction

endpackage

// File: rtl/idiv_prep.sv
module idiv_prep
   import idiv_pkg::*;
#(
   parameter int XLEN = 64
) (
   input  logic [XLEN-1:0] dvd_i,
   input  logic [XLEN-1:0] dvs_i,
   input  op_form_t        form_i,
   output logic [XLEN-1:0] num_hi_o,
   output logic [XLEN-1:0] num_lo_o,
   output logic [XLEN-1:0] den_o,
   output logic            neg_quo_o,
   output logic            neg_rem_o
);
   localparam int HALF = XLEN / 2;

   logic            a_neg, b_neg;
   logic [XLEN-1:0] a_wide, b_wide, a_mag, b_mag;

   always_comb begin
      a_neg  = form_i.sgn & (form_i.w32 ? dvd_i[HALF-1] : dvd_i[XLEN-1]);
      b_neg  = form_i.sgn & (form_i.w32 ? dvs_i[HALF-1] : dvs_i[XLEN-1]);
      a_wide = form_i.w32 ? {{HALF{a_neg}}, dvd_i[HALF-1:0]} : dvd_i;
      b_wide = form_i.w32 ? {{HALF{b_neg}}, dvs_i[HALF-1:0]} : dvs_i;
      a_mag  = a_neg ? (~a_wide + 1'b1) : a_wide;
      b_mag  = b_neg ? (~b_wide + 1'b1) : b_wide;
      if (form_i.w32) begin
         num_hi_o = '0;
         num_lo_o = form_i.ext ? {a_mag[HALF-1:0], {HALF{1'b0}}} : a_mag;
      end else begin
         num_hi_o = form_i.ext ? a_mag : '0;
         num_lo_o = form_i.ext ? '0 : a_mag;
      end
      den_o     = b_mag;
      neg_quo_o = a_neg ^ b_neg;
      neg_rem_o = a_neg;
   end
endmodule

// File: rtl/idiv_engine.sv
module idiv_engine #(
   parameter int XLEN = 64
) (
   input  logic            clk,
   input  logic            rst,
   input  logic            load_i,
   input  logic [XLEN-1:0] num_hi_i,
   input  logic [XLEN-1:0] num_lo_i,
   input  logic [XLEN-1:0] den_i,
   output logic            fin_o,
   output logic [XLEN-1:0] quo_o,
   output logic [XLEN-1:0] rem_o
);
   localparam int               CNT_W = $clog2(XLEN);
   localparam logic [CNT_W-1:0] LAST  = CNT_W'(XLEN - 1);

   logic [XLEN-1:0]  rem_q, quo_q, den_q;
   logic [CNT_W-1:0] cnt_q;
   logic             run_q, fin_q, fit_q;
   logic [XLEN:0]    shifted, trial;
   logic             take;

   always_comb begin
      shifted = {rem_q, quo_q[XLEN-1]};
      trial   = shifted - {1'b0, den_q};
      take    = ~trial[XLEN];
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         rem_q <= '0;
         quo_q <= '0;
         den_q <= '0;
         cnt_q <= '0;
         run_q <= 1'b0;
         fin_q <= 1'b0;
         fit_q <= 1'b0;
      end else begin
         fin_q <= 1'b0;
         if (load_i) begin
            rem_q <= num_hi_i;
            quo_q <= num_lo_i;
            den_q <= den_i;
            cnt_q <= '0;
            run_q <= 1'b1;
            fit_q <= num_hi_i < den_i;
         end else if (run_q) begin
            rem_q <= take ? trial[XLEN-1:0] : shifted[XLEN-1:0];
            quo_q <= {quo_q[XLEN-2:0], take};
            cnt_q <= cnt_q + 1'b1;
            if (cnt_q == LAST) begin
               run_q <= 1'b0;
               fin_q <= 1'b1;
            end
         end
      end
   end

   assign fin_o = fin_q;
   assign quo_o = quo_q;
   assign rem_o = rem_q;

   p_no_reload_r11: assert property (@(posedge clk) disable iff (rst) load_i |-> !run_q);
   p_fin_pulse_r2: assert property (@(posedge clk) disable iff (rst) fin_o |=> !fin_o);
   p_rem_bound_r6: assert property (@(posedge clk) disable iff (rst)
      (run_q && fit_q) |-> (rem_q < den_q));
endmodule

// File: rtl/idiv_finish.sv
module idiv_finish
   import idiv_pkg::*;
#(
   parameter int XLEN = 64
) (
   input  logic [XLEN-1:0]   quo_i,
   input  logic [XLEN-1:0]   rem_i,
   input  logic              w32_i,
   input  logic              mod_i,
   input  logic              neg_quo_i,
   input  logic              neg_rem_i,
   output logic [XLEN-1:0]   res_o,
   output logic [CODE_W-1:0] code_o
);
   localparam int HALF = XLEN / 2;

   logic [XLEN-1:0] pick;
   logic            flip, is_neg, is_zero;

   always_comb begin
      pick    = mod_i ? rem_i : quo_i;
      flip    = mod_i ? neg_rem_i : neg_quo_i;
      res_o   = flip ? (~pick + 1'b1) : pick;
      is_neg  = w32_i ? res_o[HALF-1] : res_o[XLEN-1];
      is_zero = w32_i ? (res_o[HALF-1:0] == '0) : (res_o == '0);
      code_o  = zero_cmp_code(is_neg, is_zero);
   end
endmodule

// File: rtl/iter_divider.sv
module iter_divider
   import idiv_pkg::*;
#(
   parameter int XLEN      = 64,
   parameter int REG_IDX_W = 5,
   parameter int CR_W      = 32,
   parameter int CR_FIELDS = 8
) (
   input  logic                 clk,
   input  logic                 rst,
   input  logic                 start_i,
   input  logic [REG_IDX_W-1:0] dest_i,
   input  logic [XLEN-1:0]      dvd_i,
   input  logic [XLEN-1:0]      dvs_i,
   input  logic                 sgn_i,
   input  logic                 w32_i,
   input  logic                 ext_i,
   input  logic                 mod_i,
   input  logic                 rec_i,
   output logic                 done_o,
   output logic                 gpr_we_o,
   output logic [REG_IDX_W-1:0] gpr_idx_o,
   output logic [XLEN-1:0]      gpr_data_o,
   output logic                 cr_we_o,
   output logic [CR_FIELDS-1:0] cr_mask_o,
   output logic [CR_W-1:0]      cr_data_o
);
   localparam logic [CR_FIELDS-1:0] SEL_MASK = {1'b1, {(CR_FIELDS-1){1'b0}}};
   localparam int                   LAT_MAX  = XLEN + 2;
   localparam int                   LAT_W    = $clog2(XLEN + 4);

   generate
      if (XLEN < 8 || (XLEN % 2) != 0) begin : g_bad_xlen
         $error("iter_divider: XLEN must be even and at least 8");
      end
      if (CR_W < CODE_W + 1) begin : g_bad_crw
         $error("iter_divider: CR_W too narrow for the condition code");
      end
      if (CR_FIELDS < 1 || REG_IDX_W < 1) begin : g_bad_misc
         $error("iter_divider: CR_FIELDS and REG_IDX_W must be positive");
      end
   endgenerate

   op_form_t             form_in;
   logic                 accept, fin;
   logic [XLEN-1:0]      num_hi, num_lo, den, quo, rem, res;
   logic                 neg_quo, neg_rem;
   logic [CODE_W-1:0]    code;

   logic                 busy_q, w32_q, mod_q, rec_q, nq_q, nr_q;
   logic [REG_IDX_W-1:0] idx_q;

   assign form_in = '{sgn: sgn_i, w32: w32_i, ext: ext_i};
   assign accept  = start_i & ~busy_q;

   idiv_prep #(.XLEN(XLEN)) u_prep (
      .dvd_i    (dvd_i),
      .dvs_i    (dvs_i),
      .form_i   (form_in),
      .num_hi_o (num_hi),
      .num_lo_o (num_lo),
      .den_o    (den),
      .neg_quo_o(neg_quo),
      .neg_rem_o(neg_rem)
   );

   idiv_engine #(.XLEN(XLEN)) u_engine (
      .clk     (clk),
      .rst     (rst),
      .load_i  (accept),
      .num_hi_i(num_hi),
      .num_lo_i(num_lo),
      .den_i   (den),
      .fin_o   (fin),
      .quo_o   (quo),
      .rem_o   (rem)
   );

   idiv_finish #(.XLEN(XLEN)) u_finish (
      .quo_i    (quo),
      .rem_i    (rem),
      .w32_i    (w32_q),
      .mod_i    (mod_q),
      .neg_quo_i(nq_q),
      .neg_rem_i(nr_q),
      .res_o    (res),
      .code_o   (code)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         busy_q     <= 1'b0;
         w32_q      <= 1'b0;
         mod_q      <= 1'b0;
         rec_q      <= 1'b0;
         nq_q       <= 1'b0;
         nr_q       <= 1'b0;
         idx_q      <= '0;
         done_o     <= 1'b0;
         gpr_we_o   <= 1'b0;
         gpr_idx_o  <= '0;
         gpr_data_o <= '0;
         cr_we_o    <= 1'b0;
         cr_mask_o  <= '0;
         cr_data_o  <= '0;
      end else begin
         done_o   <= 1'b0;
         gpr_we_o <= 1'b0;
         cr_we_o  <= 1'b0;
         if (accept) begin
            busy_q <= 1'b1;
            w32_q  <= w32_i;
            mod_q  <= mod_i;
            rec_q  <= rec_i;
            nq_q   <= neg_quo;
            nr_q   <= neg_rem;
            idx_q  <= dest_i;
         end
         if (fin) begin
            busy_q     <= 1'b0;
            done_o     <= 1'b1;
            gpr_we_o   <= 1'b1;
            gpr_idx_o  <= idx_q;
            gpr_data_o <= res;
            cr_we_o    <= rec_q;
            cr_mask_o  <= rec_q ? SEL_MASK : '0;
            cr_data_o  <= rec_q ? {code, {(CR_W-CODE_W){1'b0}}} : '0;
         end
      end
   end

   // latency observer for the assertions below
   logic [LAT_W-1:0] lat_q;
   always_ff @(posedge clk) begin
      if (rst)         lat_q <= '0;
      else if (accept) lat_q <= LAT_W'(1);
      else if (busy_q) lat_q <= lat_q + 1'b1;
   end

   p_quiet_after_start_r1: assert property (@(posedge clk) disable iff (rst) accept |=> !done_o);
   p_one_cycle_r2: assert property (@(posedge clk) disable iff (rst) done_o |=> !done_o);
   p_latency_r2: assert property (@(posedge clk) disable iff (rst)
      done_o |-> (lat_q <= LAT_W'(LAT_MAX)));
   p_gpr_with_done_r3: assert property (@(posedge clk) disable iff (rst) gpr_we_o == done_o);
   p_cr_shape_r4: assert property (@(posedge clk) disable iff (rst)
      cr_we_o |-> (done_o && cr_mask_o == SEL_MASK && cr_data_o[CR_W-CODE_W-1:0] == '0
                   && $countones(cr_data_o[CR_W-1 -: 3]) == 1 && !cr_data_o[CR_W-CODE_W]));
   p_idle_on_reset_r12: assert property (@(posedge clk) $past(rst) |-> (!done_o && !gpr_we_o && !cr_we_o));
   p_busy_holds_r11: assert property (@(posedge clk) disable iff (rst)
      (busy_q && !done_o && start_i) |=> $stable(idx_q));
endmodule

// File: tb/test_iter_divider.sv
module test_iter_divider;
   localparam int NV = 17;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        start = 1'b0;
   logic [4:0]  dest = '0;
   logic [63:0] dvd = '0, dvs = '0;
   logic        sgn = 1'b0, w32 = 1'b0, ext = 1'b0, modq = 1'b0, rec = 1'b0;
   logic        done_o, gpr_we_o, cr_we_o;
   logic [4:0]  gpr_idx_o;
   logic [63:0] gpr_data_o;
   logic [7:0]  cr_mask_o;
   logic [31:0] cr_data_o;

   int checks = 0;
   int errors = 0;

   always #10 clk = ~clk;

   iter_divider i_iter_divider (
      .clk(clk), .rst(rst), .start_i(start), .dest_i(dest), .dvd_i(dvd), .dvs_i(dvs),
      .sgn_i(sgn), .w32_i(w32), .ext_i(ext), .mod_i(modq), .rec_i(rec),
      .done_o(done_o), .gpr_we_o(gpr_we_o), .gpr_idx_o(gpr_idx_o), .gpr_data_o(gpr_data_o),
      .cr_we_o(cr_we_o), .cr_mask_o(cr_mask_o), .cr_data_o(cr_data_o)
   );

   // {dividend, divisor, mode{sgn,w32,ext,mod,rec}}
   localparam logic [132:0] VECS [NV] = '{
      {64'h0000_0000_1000_1000, 64'h0000_0000_0000_1111, 5'b00000},
      {64'h0000_0000_1000_1000, 64'h0000_0000_0000_1111, 5'b00001},
      {64'hFFFF_FFFF_FFFF_FF9C, 64'h0000_0000_0000_0007, 5'b10001},
      {64'h0000_0000_0000_0064, 64'hFFFF_FFFF_FFFF_FFF9, 5'b10000},
      {64'hFFFF_FFFF_FFFF_FFFF, 64'h0000_0000_0000_0003, 5'b00001},
      {64'hFFFF_FFFF_FFFF_FF9C, 64'h0000_0000_0000_0007, 5'b10011},
      {64'h0000_0000_0000_0064, 64'h0000_0000_0000_0007, 5'b00010},
      {64'h0000_0000_0000_0001, 64'h0000_0000_0000_0003, 5'b00100},
      {64'hFFFF_FFFF_FFFF_FFFF, 64'h0000_0000_0000_0004, 5'b10101},
      {64'hFFFF_FFFF_FFFF_FF9C, 64'h0000_0000_0000_0007, 5'b11001},
      {64'hDEAD_0000_0000_0064, 64'h1234_5678_0000_0007, 5'b01000},
      {64'h0000_0000_FFFF_FFF9, 64'h0000_0000_0000_0002, 5'b11011},
      {64'h0000_0000_0000_0001, 64'h0000_0000_0000_0004, 5'b01100},
      {64'h0000_0000_0000_0005, 64'h0000_0000_0000_0007, 5'b00001},
      {64'h0000_0000_8000_0000, 64'h0000_0000_0000_0001, 5'b01001},
      {64'h0000_0000_8000_0000, 64'h0000_0000_0000_0001, 5'b00001},
      {64'h0000_0000_FFFF_FFFF, 64'h0000_0000_0000_0008, 5'b11101}
   };

   function automatic logic [63:0] model(input logic [63:0] a, input logic [63:0] b, input logic [4:0] m);
      logic signed [127:0] sa, sb, sq;
      logic [127:0]        ua, ub, q;
      if (m[3]) begin
         ua = m[4] ? {{96{a[31]}}, a[31:0]} : {96'b0, a[31:0]};
         ub = m[4] ? {{96{b[31]}}, b[31:0]} : {96'b0, b[31:0]};
         if (m[2]) ua = ua << 32;
      end else begin
         ua = m[4] ? {{64{a[63]}}, a} : {64'b0, a};
         ub = m[4] ? {{64{b[63]}}, b} : {64'b0, b};
         if (m[2]) ua = ua << 64;
      end
      if (m[4]) begin
         sa = ua;
         sb = ub;
         if (m[1]) sq = sa % sb;
         else      sq = sa / sb;
         q = sq;
      end else begin
         if (m[1]) q = ua % ub;
         else      q = ua / ub;
      end
      return q[63:0];
   endfunction

   function automatic logic [31:0] cc_model(input logic [63:0] r, input logic narrow);
      logic n, z;
      n = narrow ? r[31] : r[63];
      z = narrow ? (r[31:0] == 32'h0) : (r == 64'h0);
      return {n, ~n & ~z, z, 1'b0, 28'h0};
   endfunction

   function automatic string tag_of(input logic [4:0] m);
      if (m[1]) return "R8";
      if (m[2]) return "R7";
      if (m[3]) return "R9";
      if (m[4]) return "R6";
      return "R3";
   endfunction

   task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   logic        cap_got, cap_we, cap_crwe;
   logic [4:0]  cap_idx;
   logic [63:0] cap_data;
   logic [7:0]  cap_mask;
   logic [31:0] cap_cr;
   int          cap_lat;

   task automatic run_op(input logic [63:0] a, input logic [63:0] b, input logic [4:0] m, input logic [4:0] idx);
      @(negedge clk);
      start = 1'b1; dest = idx; dvd = a; dvs = b;
      {sgn, w32, ext, modq, rec} = m;
      @(negedge clk);
      start = 1'b0;
      chk(done_o == 1'b0, "R1 quiet after start", {63'b0, done_o}, 64'h0);
      cap_got = 1'b0;
      cap_lat = 1;
      for (int i = 0; i < 80 && !cap_got; i++) begin
         @(negedge clk);
         cap_lat++;
         if (done_o) begin
            cap_got  = 1'b1;
            cap_we   = gpr_we_o;
            cap_idx  = gpr_idx_o;
            cap_data = gpr_data_o;
            cap_crwe = cr_we_o;
            cap_mask = cr_mask_o;
            cap_cr   = cr_data_o;
         end
      end
      chk(cap_got && cap_lat <= 66, "R2 latency", 64'(cap_lat), 64'd66);
      @(negedge clk);
      chk(done_o == 1'b0, "R2 single-cycle pulse", {63'b0, done_o}, 64'h0);
   endtask

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      errors++;
      checks++;
      $display("FAIL R2 watchdog actual=hung expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin : main
      logic [63:0] exp_r;
      logic [31:0] exp_c;
      int          pulses;

      repeat (3) @(negedge clk);
      rst = 1'b0;
      @(negedge clk);
      chk(!done_o && !gpr_we_o && !cr_we_o, "R12 reset state",
          {61'b0, done_o, gpr_we_o, cr_we_o}, 64'h0);

      for (int v = 0; v < NV; v++) begin
         run_op(VECS[v][132:69], VECS[v][68:5], VECS[v][4:0], 5'(v + 1));
         exp_r = model(VECS[v][132:69], VECS[v][68:5], VECS[v][4:0]);
         exp_c = cc_model(exp_r, VECS[v][3]);
         chk(cap_we, "R3 write enable", {63'b0, cap_we}, 64'h1);
         chk(cap_idx == 5'(v + 1), "R3 register number", 64'(cap_idx), 64'(v + 1));
         if (VECS[v][3])
            chk(cap_data[31:0] == exp_r[31:0], tag_of(VECS[v][4:0]), {32'b0, cap_data[31:0]}, {32'b0, exp_r[31:0]});
         else
            chk(cap_data == exp_r, tag_of(VECS[v][4:0]), cap_data, exp_r);
         chk(cap_crwe == VECS[v][0], "R4 cr enable", {63'b0, cap_crwe}, {63'b0, VECS[v][0]});
         if (VECS[v][0]) begin
            chk(cap_mask == 8'h80, "R4 cr mask", 64'(cap_mask), 64'h80);
            chk(cap_cr == exp_c, VECS[v][3] ? "R5 cr code narrow" : "R4 cr code", 64'(cap_cr), 64'(exp_c));
         end
         if (v == 0) chk(cap_data == 64'hF001, "R3 known quotient", cap_data, 64'hF001);
         if (v == 1) chk(cap_cr == 32'h4000_0000, "R4 positive code", 64'(cap_cr), 64'h4000_0000);
         if (v == 14) chk(cap_cr == 32'h8000_0000, "R5 narrow sign", 64'(cap_cr), 64'h8000_0000);
         if (v == 15) chk(cap_cr == 32'h4000_0000, "R5 wide sign", 64'(cap_cr), 64'h4000_0000);
      end

      // R10: zero divisor still completes
      run_op(64'h1234, 64'h0, 5'b10000, 5'd20);
      chk(cap_got && cap_we && cap_idx == 5'd20, "R10 zero divisor completes", 64'(cap_idx), 64'd20);

      // R11: second start while busy is dropped
      @(negedge clk);
      start = 1'b1; dest = 5'd3; dvd = 64'd100; dvs = 64'd7; {sgn, w32, ext, modq, rec} = 5'b00000;
      @(negedge clk);
      start = 1'b0;
      repeat (4) @(negedge clk);
      start = 1'b1; dest = 5'd9; dvd = 64'd1000; dvs = 64'd1;
      @(negedge clk);
      start = 1'b0;
      pulses = 0;
      for (int i = 0; i < 140; i++) begin
         @(negedge clk);
         if (done_o) begin
            pulses++;
            cap_idx  = gpr_idx_o;
            cap_data = gpr_data_o;
         end
      end
      chk(pulses == 1, "R11 single pulse", 64'(pulses), 64'd1);
      chk(cap_idx == 5'd3, "R11 first register kept", 64'(cap_idx), 64'd3);
      chk(cap_data == 64'd14, "R11 first result kept", cap_data, 64'd14);

      // R12: reset abandons an operation in flight
      @(negedge clk);
      start = 1'b1; dest = 5'd7; dvd = 64'd50; dvs = 64'd5;
      @(negedge clk);
      start = 1'b0;
      repeat (10) @(negedge clk);
      rst = 1'b1;
      @(negedge clk);
      rst = 1'b0;
      chk(!done_o && !gpr_we_o && !cr_we_o, "R12 enables low after reset",
          {61'b0, done_o, gpr_we_o, cr_we_o}, 64'h0);
      pulses = 0;
      for (int i = 0; i < 80; i++) begin
         @(negedge clk);
         if (done_o) pulses++;
      end
      chk(pulses == 0, "R12 abandoned op silent", 64'(pulses), 64'd0);
      run_op(64'd50, 64'd5, 5'b00000, 5'd7);
      chk(cap_data == 64'd10 && cap_idx == 5'd7, "R12 usable after reset", cap_data, 64'd10);

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule